// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer

This block drives three half-bridge legs from one shared up/down sweep counter. The counter climbs from zero to a programmed half-period value and then falls back to zero, so one switching period lasts twice that value. Each leg compares the counter against its own captured duty value. The result is a high-side pulse centered on the midpoint of the period, with a complementary low-side output. A per-leg guard stage keeps both switches of a leg off for a programmed number of cycles at every change of state.

A mode input selects how duty values are captured. In single-capture mode they are taken only at the start of each period, so every pulse is symmetric. In dual-capture mode they are taken again at the midpoint, so the two halves of the period can differ. A sync strobe of programmable width marks each capture point, and a one-cycle request pulse accompanies each strobe. A half flag shows which half of the period is running. A synchronous halt input from an external shutdown controller parks the counter and forces every switch output off.

Top module: `pwm3_timer`

## Requirements
- R1: With half-period value P (values below 2 act as 2), successive period starts are exactly 2P cycles apart. P is captured only at a period start, so a change made during a period takes effect at the next one.
- R2: `half_o` is 0 for the first P cycles of a period and 1 for the last P cycles.
- R3: In single-capture mode with duty D (0 < D < P) and guard count G (2D > G+1), cycle 0 is the cycle in which the start strobe is first seen. `hi_o` of that leg is high exactly from period cycle P-D+G+2 through period cycle P+D inclusive, which is 2D-G-1 cycles centered on the midpoint.
- R4: A duty value of 0 keeps that leg's `hi_o` low and its `lo_o` high for the whole period.
- R5: A duty value at or above P keeps that leg's `hi_o` high and its `lo_o` low for the whole period.
- R6: `hi_o` and `lo_o` of a leg are never high together. After either output falls, both stay low for G+1 cycles, so in steady state `lo_o` is high for 2P-2D-G-1 cycles per period and is last high at period cycle P-D.
- R7: In single-capture mode, a duty change made after a period start has no effect until the next period start.
- R8: In dual-capture mode (`dbl_i`=1), the duty values are captured again at the midpoint. With first-half value D1 and second-half value D2, `hi_o` is high from cycle P-D1+G+2 through cycle P+D2.
- R9: At each period start, `sync_o` goes high for W cycles beginning in period cycle 0 (a W of 0 acts as 1). `sync_irq_o` is high for one cycle, in the first cycle of each strobe.
- R10: In dual-capture mode, a further strobe and request pulse start in period cycle P. In single-capture mode there is no strobe at cycle P.
- R11: While `halt_i` is sampled high, from the next cycle onward all `hi_o`, `lo_o`, `sync_o`, `sync_irq_o` and `half_o` are low. In the cycle after the edge that first samples `halt_i` low, a new period starts (request pulse high, half flag low), and the following start comes 2P cycles later.
- R12: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Synchronous shutdown request; parks the counter and turns all switches off |
| dbl_i | input | 1 | 1 = capture duty values at the start and at the midpoint; 0 = at the start only |
| half_per_i | input | CW | Half-period length P in clock cycles |
| dead_i | input | DTW | Guard count G between complementary outputs |
| sync_w_i | input | SWW | Sync strobe width W in cycles |
| duty_i | input | PH*CW | Duty values; leg k occupies bits [k*CW +: CW] |
| hi_o | output | PH | High-side switch commands, one bit per leg |
| lo_o | output | PH | Low-side switch commands, one bit per leg |
| sync_o | output | 1 | Sync strobe |
| sync_irq_o | output | 1 | One-cycle request pulse at each strobe start |
| half_o | output | 1 | 0 in the rising half of the period, 1 in the falling half |

## Verification
The embedded properties check the cycle-level invariants on every cycle. These are: the counter never exceeds the captured half-period and steps by one while rising; the half flag never coincides with a zero count; a request pulse always sits inside a strobe; halt parks the counter and clears every switch; and the two switches of a leg never overlap or hand over without an idle cycle. The placement of pulse edges, pulse widths, duty capture timing in both modes, the midpoint strobe, period length and the restart after halt are arithmetic relations across a whole period. Only the directed scenarios, which record a full period and compare it with values derived from P, D and G, can show these.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } dir_e;
    typedef enum logic [1:0] { EV_NONE = 2'd0, EV_START = 2'd1, EV_MID = 2'd2 } ev_e;
endpackage

// File: rtl/pwm3_sweep.sv
module pwm3_sweep
    import pwm3_pkg::*;
#(
    parameter int CW  = 16,
    parameter int SWW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           halt_i,
    input  logic           dbl_i,
    input  logic [CW-1:0]  half_per_i,
    input  logic [SWW-1:0] sync_w_i,
    output logic [CW-1:0]  cnt_o,
    output logic [CW-1:0]  per_o,
    output dir_e           dir_o,
    output ev_e            ev_o,
    output logic           sync_o,
    output logic           irq_o
);
    localparam logic [CW-1:0] MIN_PER = CW'(2);

    typedef struct packed {
        logic [CW-1:0]  cnt;
        dir_e           dir;
        logic           idle;
        logic [CW-1:0]  per;
        logic [SWW-1:0] rem;
        logic           sync;
        logic           irq;
    } sweep_t;

    sweep_t st_q, st_d;
    ev_e    ev;
    logic   fire;

    always_comb begin
        st_d = st_q;
        ev   = EV_NONE;
        fire = 1'b0;
        if (halt_i) begin
            st_d.cnt  = '0;
            st_d.dir  = DIR_UP;
            st_d.idle = 1'b1;
            st_d.rem  = '0;
            st_d.sync = 1'b0;
            st_d.irq  = 1'b0;
        end else begin
            if (st_q.idle) begin
                st_d.idle = 1'b0;
                st_d.cnt  = '0;
                st_d.dir  = DIR_UP;
                ev        = EV_START;
            end else if (st_q.dir == DIR_UP) begin
                if (st_q.cnt == st_q.per - CW'(1)) begin
                    st_d.cnt = st_q.per;
                    st_d.dir = DIR_DOWN;
                    ev       = EV_MID;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end else begin
                if (st_q.cnt <= CW'(1)) begin
                    st_d.cnt = '0;
                    st_d.dir = DIR_UP;
                    ev       = EV_START;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            if (ev == EV_START) begin
                st_d.per = (half_per_i < MIN_PER) ? MIN_PER : half_per_i;
            end
            fire = (ev == EV_START) || ((ev == EV_MID) && dbl_i);
            if (fire) begin
                st_d.sync = 1'b1;
                st_d.irq  = 1'b1;
                st_d.rem  = (sync_w_i == '0) ? '0 : sync_w_i - SWW'(1);
            end else begin
                st_d.irq = 1'b0;
                if (st_q.rem != '0) begin
                    st_d.rem  = st_q.rem - SWW'(1);
                    st_d.sync = 1'b1;
                end else begin
                    st_d.sync = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: DIR_UP, idle: 1'b1, per: MIN_PER,
                      rem: '0, sync: 1'b0, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign per_o  = st_q.per;
    assign dir_o  = st_q.dir;
    assign ev_o   = ev;
    assign sync_o = st_q.sync;
    assign irq_o  = st_q.irq;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.per);
    p_rise_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && !st_q.idle && st_q.dir == DIR_UP && st_q.cnt < st_q.per - CW'(1))
        |=> (st_q.cnt == $past(st_q.cnt) + CW'(1)));
    p_half_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dir == DIR_DOWN) |-> (st_q.cnt != '0));
    p_irq_in_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> st_q.sync);
    p_halt_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (st_q.cnt == '0 && !st_q.sync && st_q.dir == DIR_UP));
endmodule

// File: rtl/pwm3_guard.sv
module pwm3_guard #(
    parameter int DTW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           halt_i,
    input  logic           want_i,
    input  logic [DTW-1:0] dead_i,
    output logic           hi_o,
    output logic           lo_o
);
    typedef struct packed {
        logic           tgt;
        logic [DTW-1:0] wait_cnt;
        logic           hi;
        logic           lo;
    } guard_t;

    guard_t g_q, g_d;

    always_comb begin
        g_d = g_q;
        if (halt_i) begin
            g_d = '0;
        end else if (want_i != g_q.tgt) begin
            g_d.tgt      = want_i;
            g_d.wait_cnt = dead_i;
            g_d.hi       = 1'b0;
            g_d.lo       = 1'b0;
        end else if (g_q.wait_cnt != '0) begin
            g_d.wait_cnt = g_q.wait_cnt - DTW'(1);
            g_d.hi       = 1'b0;
            g_d.lo       = 1'b0;
        end else begin
            g_d.hi = g_q.tgt;
            g_d.lo = !g_q.tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign hi_o = g_q.hi;
    assign lo_o = g_q.lo;

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(g_q.hi && g_q.lo));
    p_hi_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.hi) |-> $past(!g_q.lo));
    p_lo_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.lo) |-> $past(!g_q.hi));
    p_halt_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (!g_q.hi && !g_q.lo));
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
    import pwm3_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DTW = 10,
    parameter int SWW = 8,
    parameter int PH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              dbl_i,
    input  logic [CW-1:0]     half_per_i,
    input  logic [DTW-1:0]    dead_i,
    input  logic [SWW-1:0]    sync_w_i,
    input  logic [PH*CW-1:0]  duty_i,
    output logic [PH-1:0]     hi_o,
    output logic [PH-1:0]     lo_o,
    output logic              sync_o,
    output logic              sync_irq_o,
    output logic              half_o
);
    typedef struct packed {
        logic [PH-1:0][CW-1:0] duty;
    } lat_t;

    logic [CW-1:0] cnt, per;
    dir_e          dir;
    ev_e           ev;
    lat_t          lat_q, lat_d;

    pwm3_sweep #(.CW(CW), .SWW(SWW)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_i     (halt_i),
        .dbl_i      (dbl_i),
        .half_per_i (half_per_i),
        .sync_w_i   (sync_w_i),
        .cnt_o      (cnt),
        .per_o      (per),
        .dir_o      (dir),
        .ev_o       (ev),
        .sync_o     (sync_o),
        .irq_o      (sync_irq_o)
    );

    always_comb begin
        lat_d = lat_q;
        if (ev == EV_START || (ev == EV_MID && dbl_i)) begin
            for (int k = 0; k < PH; k++) begin
                lat_d.duty[k] = duty_i[k*CW +: CW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign half_o = (dir == DIR_DOWN);

    for (genvar g = 0; g < PH; g++) begin : g_leg
        logic [CW-1:0] lvl_c, thr_c;
        logic          want_c;

        always_comb begin
            lvl_c  = (dir == DIR_DOWN) ? cnt - CW'(1) : cnt;
            thr_c  = (lat_q.duty[g] >= per) ? '0 : per - lat_q.duty[g];
            want_c = (lvl_c >= thr_c);
        end

        pwm3_guard #(.DTW(DTW)) u_guard (
            .clk    (clk),
            .rst_n  (rst_n),
            .halt_i (halt_i),
            .want_i (want_c),
            .dead_i (dead_i),
            .hi_o   (hi_o[g]),
            .lo_o   (lo_o[g])
        );
    end

    p_single_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_i && sync_irq_o && half_o) |-> 1'b0);
    p_mid_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_irq_o && !half_o) |-> (cnt == '0));
endmodule

// File: tb/pwm3_timer_bench.sv
`timescale 1ns/1ps
module pwm3_timer_bench;
    localparam int CW = 16, DTW = 10, SWW = 8, PH = 3;

    logic clk = 1'b0;
    logic rst_n, halt, dbl;
    logic [CW-1:0]    hp;
    logic [DTW-1:0]   dt;
    logic [SWW-1:0]   sw;
    logic [PH*CW-1:0] duty;
    logic [PH-1:0]    hi_o, lo_o;
    logic             sync_o, sync_irq_o, half_o;

    always #2.5 clk = ~clk;

    pwm3_timer #(.CW(CW), .DTW(DTW), .SWW(SWW), .PH(PH)) u_pwm3_timer (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .dbl_i(dbl),
        .half_per_i(hp), .dead_i(dt), .sync_w_i(sw), .duty_i(duty),
        .hi_o(hi_o), .lo_o(lo_o), .sync_o(sync_o),
        .sync_irq_o(sync_irq_o), .half_o(half_o)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [PH-1:0] r_hi [0:127];
    logic [PH-1:0] r_lo [0:127];
    logic r_sync [0:127];
    logic r_irq  [0:127];
    logic r_half [0:127];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [PH*CW-1:0] pack3(input int a, input int b, input int c);
        return {CW'(c), CW'(b), CW'(a)};
    endfunction

    function automatic int cnt_hi(input int ph, input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += int'(r_hi[i][ph]);
        return s;
    endfunction

    function automatic int cnt_lo(input int ph, input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += int'(r_lo[i][ph]);
        return s;
    endfunction

    function automatic int first_hi(input int ph, input int n);
        for (int i = 0; i < n; i++) if (r_hi[i][ph]) return i;
        return -1;
    endfunction

    function automatic int last_hi(input int ph, input int n);
        int l = -1;
        for (int i = 0; i < n; i++) if (r_hi[i][ph]) l = i;
        return l;
    endfunction

    function automatic int last_lo(input int ph, input int n);
        int l = -1;
        for (int i = 0; i < n; i++) if (r_lo[i][ph]) l = i;
        return l;
    endfunction

    function automatic int overlaps(input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += $countones(r_hi[i] & r_lo[i]);
        return s;
    endfunction

    function automatic int cnt_sync(input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += int'(r_sync[i]);
        return s;
    endfunction

    function automatic int cnt_irq(input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += int'(r_irq[i]);
        return s;
    endfunction

    task automatic wait_start();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!(sync_irq_o && !half_o) && guard < 1000);
    endtask

    task automatic gap_to_start(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(sync_irq_o && !half_o) && n < 1000);
    endtask

    task automatic grab(input int n, input int chg_at, input logic [PH*CW-1:0] nd);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            r_hi[i] = hi_o; r_lo[i] = lo_o; r_sync[i] = sync_o;
            r_irq[i] = sync_irq_o; r_half[i] = half_o;
            if (i == chg_at) duty = nd;
        end
    endtask

    task automatic start_run(input int p, input int g, input int w, input logic m,
                             input logic [PH*CW-1:0] d);
        @(negedge clk);
        halt = 1'b1; hp = CW'(p); dt = DTW'(g); sw = SWW'(w); dbl = m; duty = d;
        repeat (3) @(negedge clk);
        halt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12", "outputs in reset", int'({hi_o, lo_o, sync_o, sync_irq_o, half_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "outputs while halted", int'({hi_o, lo_o, sync_o, sync_irq_o, half_o}), 0);
    endtask

    task automatic t_center();
        start_run(20, 3, 2, 1'b0, pack3(5, 10, 15));
        wait_start(); wait_start();
        grab(41, -1, '0);
        for (int ph = 0; ph < PH; ph++) begin
            int d = 5 * (ph + 1);
            chk("R3", "hi width", cnt_hi(ph, 40), 2*d - 4);
            chk("R3", "hi first cycle", first_hi(ph, 40), 25 - d);
            chk("R3", "hi last cycle", last_hi(ph, 40), 20 + d);
            chk("R6", "lo width", cnt_lo(ph, 40), 36 - 2*d);
            chk("R6", "lo last in first half", last_lo(ph, 20), 20 - d);
        end
        chk("R6", "overlap cycles", overlaps(40), 0);
        chk("R2", "half high count", cnt_irq(0) + int'(r_half[20]) + int'(r_half[39]), 2);
        chk("R2", "half low at 19", int'(r_half[19]), 0);
        chk("R2", "half low at 0", int'(r_half[0]), 0);
        chk("R1", "next start at 40", int'(r_irq[40] && !r_half[40]), 1);
        chk("R9", "strobe width", cnt_sync(40), 2);
        chk("R9", "strobe at 0 and 1", int'(r_sync[0] && r_sync[1]), 1);
        chk("R9", "request count", cnt_irq(40), 1);
        chk("R10", "no mid strobe in single", int'(r_sync[20]), 0);
    endtask

    task automatic t_extremes();
        start_run(20, 3, 2, 1'b0, pack3(0, 20, 45));
        wait_start(); wait_start();
        grab(40, -1, '0);
        chk("R4", "zero duty hi", cnt_hi(0, 40), 0);
        chk("R4", "zero duty lo", cnt_lo(0, 40), 40);
        chk("R5", "duty=P hi", cnt_hi(1, 40), 40);
        chk("R5", "duty=P lo", cnt_lo(1, 40), 0);
        chk("R5", "duty>P hi", cnt_hi(2, 40), 40);
        chk("R5", "duty>P lo", cnt_lo(2, 40), 0);
    endtask

    task automatic t_single_hold();
        start_run(20, 3, 2, 1'b0, pack3(5, 10, 15));
        wait_start(); wait_start();
        grab(41, 3, pack3(15, 15, 15));
        chk("R7", "leg0 width unchanged", cnt_hi(0, 40), 6);
        chk("R7", "leg1 width unchanged", cnt_hi(1, 40), 16);
        chk("R7", "leg2 width unchanged", cnt_hi(2, 40), 26);
        grab(40, -1, '0);
        for (int ph = 0; ph < PH; ph++)
            chk("R7", "new duty at next start", cnt_hi(ph, 40), 26);
    endtask

    task automatic t_double();
        start_run(20, 3, 2, 1'b1, pack3(8, 8, 8));
        wait_start(); wait_start();
        grab(41, 3, pack3(4, 12, 16));
        for (int ph = 0; ph < PH; ph++) begin
            int d2 = (ph == 0) ? 4 : ((ph == 1) ? 12 : 16);
            chk("R8", "hi first cycle", first_hi(ph, 40), 17);
            chk("R8", "hi last cycle", last_hi(ph, 40), 20 + d2);
            chk("R8", "hi width", cnt_hi(ph, 40), 8 + d2 - 4);
        end
        chk("R6", "overlap in dual mode", overlaps(40), 0);
        chk("R10", "mid strobe", int'(r_sync[20] && r_sync[21]), 1);
        chk("R10", "mid request", int'(r_irq[20]), 1);
        chk("R10", "requests per period", cnt_irq(40), 2);
        chk("R1", "dual period length", int'(r_irq[40] && !r_half[40]), 1);
    endtask

    task automatic t_width_zero();
        start_run(20, 3, 0, 1'b0, pack3(5, 10, 15));
        wait_start();
        grab(40, -1, '0);
        chk("R9", "zero width acts as one", cnt_sync(40), 1);
        chk("R9", "zero width strobe at 0", int'(r_sync[0]), 1);
    endtask

    task automatic t_halt();
        int n, bad;
        start_run(20, 3, 2, 1'b0, pack3(5, 10, 15));
        wait_start(); wait_start();
        repeat (7) @(negedge clk);
        halt = 1'b1;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if ({hi_o, lo_o, sync_o, sync_irq_o, half_o} != '0) bad++;
            if (i == 5) halt = 1'b0;
        end
        chk("R11", "cycles with outputs active in halt", bad, 0);
        @(negedge clk);
        chk("R11", "restart request", int'(sync_irq_o && !half_o), 1);
        gap_to_start(n);
        chk("R11", "first period after halt", n, 40);
    endtask

    task automatic t_clamp();
        int n;
        start_run(1, 0, 1, 1'b0, pack3(0, 0, 0));
        wait_start();
        gap_to_start(n);
        chk("R1", "half-period 1 acts as 2", n, 4);
        @(negedge clk);
        hp = CW'(10);
        n = 1;
        begin
            int m;
            gap_to_start(m);
            n += m;
        end
        chk("R1", "period kept after mid change", n, 4);
        gap_to_start(n);
        chk("R1", "new period at next start", n, 20);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; halt = 1'b1; dbl = 1'b0; hp = CW'(20); dt = DTW'(3);
        sw = SWW'(2); duty = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_center();
        t_extremes();
        t_single_hold();
        t_double();
        t_width_zero();
        t_halt();
        t_clamp();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule